// File: doc/BRIEF.md
# Correlating Two-Level Branch Direction Predictor

This block guesses whether a conditional branch will be taken. It combines the low-order bits of the branch address with the outcomes of the most recent branches seen anywhere in the program. The address bits pick a row of the pattern table. The short global outcome history then picks one of the counters inside that row. Each counter is a small saturating up/down counter, and its upper half of states means "taken". Because of this, a single surprising outcome does not reverse a strongly held guess.

Fetch presents an address on the lookup port and receives the direction and the raw counter in the same cycle. When a branch resolves, the execute stage sends back its address and its real outcome on the update port. The counter is chosen with the history as it stood before this branch. The counter is then trained, and the outcome is shifted into the history. There is no tag check, so branches whose index bits match share counters. The default build has 256 rows of 4 counters, which gives 1024 entries.

Top module: `corr_bpred`

## Requirements
- R1: After reset the global history is 00 and every counter holds 1 (weakly not taken), so any lookup returns pred_ctr = 1 and pred_taken = 0.
- R2: An update with upd_taken = 1 adds one to the selected counter, which stays at 3 once there.
- R3: An update with upd_taken = 0 subtracts one from the selected counter, which stays at 0 once there.
- R4: pred_taken is 1 exactly when pred_ctr is 2 or 3.
- R5: Each update shifts its outcome into history bit 0, and the old bit 0 moves to bit 1; only the last two outcomes are kept.
- R6: The row is pc[9:2] (PC_LSB = 2, IDX_W = 8), and the counter within the row is selected by the 2-bit history, i.e. table index = {row, history}.
- R7: An update trains the counter selected by the history value held before that update; a lookup in the cycle after the update uses the new history.
- R8: Addresses that differ only outside pc[9:2] map to the same counters, with no tag comparison.
- R9: With upd_valid = 0, neither the counters nor the history change, whatever upd_pc and upd_taken carry.
- R10: A counter in a strong state (0 or 3) keeps its predicted direction after one opposing outcome and flips it after a second consecutive one.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous reset, active low |
| pred_pc | input | PC_W | Address of the branch being looked up |
| pred_taken | output | 1 | Predicted direction, 1 = taken |
| pred_ctr | output | CTR_W | Value of the selected counter |
| upd_valid | input | 1 | Update strobe for a resolved branch |
| upd_pc | input | PC_W | Address of the resolved branch |
| upd_taken | input | 1 | Resolved outcome, 1 = taken |

## Verification
The bench builds the block with its default parameters: 16-bit addresses, word alignment dropping two bits, 8 row bits, 2 history bits and 2-bit counters. This gives 1024 two-bit entries. With that shape, the bench can reach an alias address one bit above the row field, and it can hold the history at 00 by interleaving not-taken branches from another row. Holding the history at 00 lets it read back a single slot after consecutive opposing outcomes. The short counters reach both saturation limits within a few updates.

// File: rtl/bp_pkg.sv
package bp_pkg;
   // default geometry of the predictor
   localparam int unsigned DEF_PC_W   = 16;
   localparam int unsigned DEF_PC_LSB = 2;
   localparam int unsigned DEF_IDX_W  = 8;
   localparam int unsigned DEF_HIST_W = 2;
   localparam int unsigned DEF_CTR_W  = 2;

   typedef enum logic {
      BR_NOT_TAKEN = 1'b0,
      BR_TAKEN     = 1'b1
   } br_dir_e;
endpackage

// File: rtl/bp_ctr_step.sv
module bp_ctr_step #(
   parameter int unsigned CTR_W = 2
) (
   input  logic [CTR_W-1:0] cur,
   input  logic             dir_taken,
   output logic [CTR_W-1:0] nxt
);
   localparam logic [CTR_W-1:0] CTR_MAX = {CTR_W{1'b1}};
   localparam logic [CTR_W-1:0] CTR_MIN = '0;
   localparam logic [CTR_W-1:0] ONE     = {{(CTR_W-1){1'b0}}, 1'b1};

   generate
      if (CTR_W < 2) begin : g_bad_width
         $error("bp_ctr_step: CTR_W must be at least 2");
      end
   endgenerate

   always_comb begin
      nxt = cur;
      if (dir_taken) begin
         if (cur != CTR_MAX) nxt = cur + ONE;
      end else begin
         if (cur != CTR_MIN) nxt = cur - ONE;
      end
   end
endmodule

// File: rtl/bp_ghist.sv
module bp_ghist #(
   parameter int unsigned HIST_W = 2
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              shift_en,
   input  logic              shift_in,
   output logic [HIST_W-1:0] hist
);
   generate
      if (HIST_W < 1) begin : g_bad_hist
         $error("bp_ghist: HIST_W must be at least 1");
      end else if (HIST_W == 1) begin : g_one
         always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n)        hist <= '0;
            else if (shift_en) hist <= shift_in;
         end
      end else begin : g_multi
         always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n)        hist <= '0;
            else if (shift_en) hist <= {hist[HIST_W-2:0], shift_in};
         end
      end
   endgenerate

   // history is untouched without an update
   p_hold_r9: assert property (@(posedge clk) disable iff (!rst_n)
      !shift_en |=> $stable(hist));

   // newest outcome lands in bit 0
   p_newest_r5: assert property (@(posedge clk) disable iff (!rst_n)
      shift_en |=> hist[0] == $past(shift_in));

   generate
      if (HIST_W > 1) begin : g_age_chk
         // older outcome moves up one place
         p_age_r5: assert property (@(posedge clk) disable iff (!rst_n)
            shift_en |=> hist[1] == $past(hist[0]));
      end
   endgenerate
endmodule

// File: rtl/bp_pht.sv
module bp_pht #(
   parameter int unsigned ADDR_W = 10,
   parameter int unsigned CTR_W  = 2,
   parameter int unsigned RST_VAL = 1
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic [ADDR_W-1:0] rd_idx,
   output logic [CTR_W-1:0]  rd_ctr,
   input  logic              wr_en,
   input  logic [ADDR_W-1:0] wr_idx,
   input  logic              wr_taken
);
   localparam int unsigned    DEPTH    = 1 << ADDR_W;
   localparam logic [CTR_W-1:0] CTR_INIT = CTR_W'(RST_VAL);
   localparam logic [CTR_W-1:0] CTR_MAX  = {CTR_W{1'b1}};

   generate
      if (RST_VAL > ((1 << CTR_W) - 1)) begin : g_bad_init
         $error("bp_pht: RST_VAL does not fit in CTR_W bits");
      end
      if (ADDR_W > 12) begin : g_bad_depth
         $error("bp_pht: table larger than 4096 entries");
      end
   endgenerate

   logic [CTR_W-1:0] tbl [DEPTH];
   logic [CTR_W-1:0] wr_old;
   logic [CTR_W-1:0] wr_new;

   assign rd_ctr = tbl[rd_idx];
   assign wr_old = tbl[wr_idx];

   bp_ctr_step #(.CTR_W(CTR_W)) u_step (
      .cur       (wr_old),
      .dir_taken (wr_taken),
      .nxt       (wr_new)
   );

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         for (int i = 0; i < DEPTH; i++) tbl[i] <= CTR_INIT;
      end else if (wr_en) begin
         tbl[wr_idx] <= wr_new;
      end
   end

   // record of the last write, used only by the properties below
   logic              chk_wr_q;
   logic              chk_dir_q;
   logic [ADDR_W-1:0] chk_idx_q;
   logic [CTR_W-1:0]  chk_old_q;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         chk_wr_q  <= 1'b0;
         chk_dir_q <= 1'b0;
         chk_idx_q <= '0;
         chk_old_q <= '0;
      end else begin
         chk_wr_q  <= wr_en;
         chk_dir_q <= wr_taken;
         chk_idx_q <= wr_idx;
         chk_old_q <= wr_old;
      end
   end

   logic [CTR_W-1:0] chk_now;
   assign chk_now = tbl[chk_idx_q];

   // taken moves the slot up by one, or holds it at the top
   p_count_up_r2: assert property (@(posedge clk) disable iff (!rst_n)
      (chk_wr_q && chk_dir_q) |->
         ((chk_old_q == CTR_MAX) ? (chk_now == CTR_MAX)
                                 : (chk_now == chk_old_q + 1'b1)));

   // not taken moves the slot down by one, or holds it at zero
   p_count_dn_r3: assert property (@(posedge clk) disable iff (!rst_n)
      (chk_wr_q && !chk_dir_q) |->
         ((chk_old_q == '0) ? (chk_now == '0)
                            : (chk_now == chk_old_q - 1'b1)));

   // a strong state survives one opposing outcome with its direction
   p_hysteresis_r10: assert property (@(posedge clk) disable iff (!rst_n)
      (chk_wr_q && (chk_old_q == CTR_MAX || chk_old_q == '0)) |->
         (chk_now[CTR_W-1] == chk_old_q[CTR_W-1]));
endmodule

// File: rtl/corr_bpred.sv
module corr_bpred
   import bp_pkg::*;
#(
   parameter int unsigned PC_W   = DEF_PC_W,
   parameter int unsigned PC_LSB = DEF_PC_LSB,
   parameter int unsigned IDX_W  = DEF_IDX_W,
   parameter int unsigned HIST_W = DEF_HIST_W,
   parameter int unsigned CTR_W  = DEF_CTR_W
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic [PC_W-1:0]  pred_pc,
   output logic             pred_taken,
   output logic [CTR_W-1:0] pred_ctr,
   input  logic             upd_valid,
   input  logic [PC_W-1:0]  upd_pc,
   input  logic             upd_taken
);
   localparam int unsigned ADDR_W   = IDX_W + HIST_W;
   localparam int unsigned THRESH   = 1 << (CTR_W - 1);
   localparam int unsigned INIT_VAL = THRESH - 1;

   generate
      if (PC_LSB + IDX_W > PC_W) begin : g_bad_pc
         $error("corr_bpred: row field exceeds the address width");
      end
      if (IDX_W < 1) begin : g_bad_idx
         $error("corr_bpred: IDX_W must be at least 1");
      end
   endgenerate

   logic [HIST_W-1:0] hist;
   logic [IDX_W-1:0]  pred_row;
   logic [IDX_W-1:0]  upd_row;
   logic [ADDR_W-1:0] pred_idx;
   logic [ADDR_W-1:0] upd_idx;
   br_dir_e           upd_dir;

   assign pred_row = pred_pc[PC_LSB +: IDX_W];
   assign upd_row  = upd_pc[PC_LSB +: IDX_W];
   // history as held before this update picks the slot
   assign pred_idx = {pred_row, hist};
   assign upd_idx  = {upd_row, hist};
   assign upd_dir  = upd_taken ? BR_TAKEN : BR_NOT_TAKEN;

   bp_ghist #(.HIST_W(HIST_W)) u_hist (
      .clk      (clk),
      .rst_n    (rst_n),
      .shift_en (upd_valid),
      .shift_in (upd_dir == BR_TAKEN),
      .hist     (hist)
   );

   bp_pht #(
      .ADDR_W  (ADDR_W),
      .CTR_W   (CTR_W),
      .RST_VAL (INIT_VAL)
   ) u_pht (
      .clk      (clk),
      .rst_n    (rst_n),
      .rd_idx   (pred_idx),
      .rd_ctr   (pred_ctr),
      .wr_en    (upd_valid),
      .wr_idx   (upd_idx),
      .wr_taken (upd_dir == BR_TAKEN)
   );

   assign pred_taken = (pred_ctr >= CTR_W'(THRESH));

   // direction follows the counter's top bit
   p_dir_top_bit_r4: assert property (@(posedge clk) disable iff (!rst_n)
      pred_taken == pred_ctr[CTR_W-1]);

   // the first cycle out of reset sees a weak not-taken slot
   p_reset_state_r1: assert property (@(posedge clk)
      $rose(rst_n) |-> (pred_ctr == CTR_W'(INIT_VAL) && !pred_taken));
endmodule

// File: tb/corr_bpred_test.sv
module corr_bpred_test;
   localparam int CLK_PERIOD = 10;

   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic [15:0] pred_pc = '0;
   logic        pred_taken;
   logic [1:0]  pred_ctr;
   logic        upd_valid = 1'b0;
   logic [15:0] upd_pc = '0;
   logic        upd_taken = 1'b0;

   int checks = 0;
   int errors = 0;
   bit done = 1'b0;

   always #(CLK_PERIOD/2) clk = ~clk;

   corr_bpred uut (
      .clk        (clk),
      .rst_n      (rst_n),
      .pred_pc    (pred_pc),
      .pred_taken (pred_taken),
      .pred_ctr   (pred_ctr),
      .upd_valid  (upd_valid),
      .upd_pc     (upd_pc),
      .upd_taken  (upd_taken)
   );

   localparam logic [15:0] PC_A     = 16'h0010; // row 4
   localparam logic [15:0] PC_A_ALI = 16'h0410; // row 4, differs above the row field
   localparam logic [15:0] PC_B     = 16'h0014; // row 5

   // {outcome, expected counter at PC_A after the update}
   localparam int NVEC = 11;
   localparam logic [2:0] VEC [NVEC] = '{
      3'b1_01, 3'b1_01, 3'b1_10, 3'b1_11, 3'b1_11,
      3'b0_01, 3'b0_10, 3'b0_01, 3'b0_00, 3'b0_00,
      3'b1_10
   };

   task automatic check_ctr(input string tag, input logic [1:0] exp);
      logic exp_dir;
      exp_dir = (exp >= 2'd2);
      checks++;
      if (pred_ctr !== exp || pred_taken !== exp_dir) begin
         errors++;
         $display("FAIL %s: ctr=%0d taken=%0d expected ctr=%0d taken=%0d",
                  tag, pred_ctr, pred_taken, exp, exp_dir);
      end
   endtask

   task automatic lookup(input logic [15:0] pc);
      pred_pc = pc;
      #1;
   endtask

   task automatic update(input logic [15:0] pc, input logic t);
      @(negedge clk);
      upd_valid = 1'b1;
      upd_pc    = pc;
      upd_taken = t;
      @(negedge clk);
      upd_valid = 1'b0;
   endtask

   task automatic do_reset();
      @(negedge clk);
      rst_n = 1'b0;
      @(negedge clk);
      rst_n = 1'b1;
      @(negedge clk);
   endtask

   initial begin
      do_reset();

      // R1: reset state seen at several rows
      lookup(PC_A);      check_ctr("R1 row4", 2'd1);
      lookup(16'h03FC);  check_ctr("R1 row255", 2'd1);
      lookup(16'h0000);  check_ctr("R1 row0", 2'd1);

      // R2 R3 R4 R5 R6 R7: walk of updates on one branch, history selecting slots
      for (int i = 0; i < NVEC; i++) begin
         update(PC_A, VEC[i][2]);
         lookup(PC_A);
         check_ctr($sformatf("R2/R3/R5/R7 step %0d", i), VEC[i][1:0]);
      end

      // R9: strobe low with a live-looking payload, history stays 01
      @(negedge clk);
      upd_valid = 1'b0; upd_pc = PC_A; upd_taken = 1'b0;
      @(negedge clk);
      @(negedge clk);
      lookup(PC_A);     check_ctr("R9 no update", 2'd2);

      // R8: alias above the row field reads the same counter
      lookup(PC_A_ALI); check_ctr("R8 alias", 2'd2);
      // R6: neighbouring row untouched
      lookup(PC_B);     check_ctr("R6 other row", 2'd1);

      // R10: build a strong slot at history 00, then oppose it twice
      do_reset();
      update(PC_A, 1'b1);   // slot {4,00}=2, hist 01
      update(PC_B, 1'b0);   // hist 10
      update(PC_B, 1'b0);   // hist 00
      update(PC_A, 1'b1);   // slot {4,00}=3, hist 01
      update(PC_B, 1'b0);   // hist 10
      update(PC_B, 1'b0);   // hist 00
      lookup(PC_A);     check_ctr("R2 R7 strong taken", 2'd3);
      update(PC_A, 1'b0);   // hist stays 00
      lookup(PC_A);     check_ctr("R10 one miss keeps taken", 2'd2);
      update(PC_A, 1'b0);
      lookup(PC_A);     check_ctr("R10 two misses flip", 2'd1);
      update(PC_A, 1'b0);
      update(PC_A, 1'b0);
      lookup(PC_A);     check_ctr("R3 floor", 2'd0);
      // R1: reset mid-run restores weak not-taken
      do_reset();
      lookup(PC_A);     check_ctr("R1 after rerun reset", 2'd1);

      done = 1'b1;
      $display("  CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
   end

   initial begin
      #(CLK_PERIOD * 20000);
      if (!done) begin
         checks++;
         errors++;
         $display("FAIL watchdog: run did not finish, expected completion");
         $display("  CHECKS %0d ERRORS %0d", checks, errors);
         $finish;
      end
   end
endmodule